// File: doc/BRIEF.md
# Program-Counter Function Tracker

This block takes a stream of sampled program-counter values, one per clock at most, and turns it into a stream of function-entry events. Each sample is looked up in a table of function start addresses, sorted ascending and loaded before tracking begins. The sample is assigned to the function whose start address is the largest one not above it. A record is produced only when that function differs from the one reported last, so long runs inside one function collapse to a single event.

Each record carries the function index and a timestamp. The timestamp is taken from a free-running clock counter at the moment the sample was accepted. Records wait in an output queue until an external controller drains it. The lookup is a binary search unrolled into one compare per pipeline stage. The block therefore never stalls its input, whatever the sample rate. When the queue is full, new records are discarded and counted.

Top module: `pc_func_tracer`

## Requirements
- R1: After reset `outValid` is 0, `dropCount` is 0 and the timestamp counter is 0.
- R2: With `lookupEn` high, a sample whose `pcValue` is at or above table entry 0 maps to the largest index i below the entry count with entry i ≤ `pcValue`. The table must hold ascending addresses in positions 0 up to count-1.
- R3: A sample below entry 0, or any sample while the entry count is 0, maps to the reserved unknown index 2^IDX_W, which is the index MSB set and the rest zero.
- R4: Table positions at or above the entry count never take part in the result, whatever they hold.
- R5: A record is emitted only when the sample's index differs from the index of the last sample that passed the filter. Every dropped record still counts as having passed. The first valid sample after reset always passes, and the unknown index is filtered like any other index.
- R6: A new sample is accepted on every clock. A sample accepted at edge t is pushed into the queue at edge t+IDX_W+1.
- R7: `outTime` holds the counter value at the accepting edge. The counter reads 0 at the first edge after reset, then advances by one per clock and wraps.
- R8: `pcValid` has no effect while `lookupEn` is low.
- R9: Records leave in arrival order. `outRead` pops the head when `outValid` is high and is ignored when the queue is empty.
- R10: A record that arrives while the queue holds FIFO_DEPTH entries is discarded, even if the same edge pops one. Each discard adds one to `dropCount`, which saturates at all ones.
- R11: `tblWrEn` writes `tblWrData` to table position `tblWrAddr`, and `cntWrEn` sets the entry count to `cntWrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tblWrEn | input | 1 | Table entry write strobe |
| tblWrAddr | input | IDX_W | Table position to write |
| tblWrData | input | ADDR_W | Function start address |
| cntWrEn | input | 1 | Entry count write strobe |
| cntWrData | input | IDX_W+1 | Number of valid table entries |
| lookupEn | input | 1 | Enables sample acceptance |
| pcValid | input | 1 | Sample present this cycle |
| pcValue | input | ADDR_W | Sampled program counter |
| outRead | input | 1 | Pop the head record |
| outValid | output | 1 | Queue holds at least one record |
| outIdx | output | IDX_W+1 | Function index of the head record |
| outTime | output | TS_W | Timestamp of the head record |
| dropCount | output | DROP_W | Saturating count of discarded records |

## Verification
The bench builds the block with IDX_W=4 and a 16-entry table, so the search pipeline is four stages deep. It uses a four-entry queue and a 3-bit drop counter. A table of ten functions, with junk above the count, exercises the count boundary and the unknown index. The small queue fills after four undrained records. The drop counter reaches saturation at 7 within a few dozen cycles of alternating samples. A behavioural model does a linear scan of the table and keeps plain queues. Its results are compared with every output on every clock, so latency, ordering and timestamps are all checked exactly.

// File: rtl/pcft_pkg.sv
package pcft_pkg;
  // Strobes from control to the record queue
  typedef struct packed {
    logic push;
    logic pop;
  } fifoCmd_t;
endpackage

// File: rtl/pcft_lookup.sv
module pcft_lookup #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrAddr,
  input  logic [ADDR_W-1:0] tblWrData,
  input  logic              cntWrEn,
  input  logic [IDX_W:0]    cntWrData,
  input  logic              sampleVld,
  input  logic [ADDR_W-1:0] sampleAddr,
  output logic              resVld,
  output logic [IDX_W:0]    resIdx,
  output logic [TS_W-1:0]   resTs
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [IDX_W:0] UNKNOWN_IDX = (IDX_W+1)'(ENTRIES);

  logic [ADDR_W-1:0] startTbl [ENTRIES];
  logic [IDX_W:0]    entryCnt;
  logic [TS_W-1:0]   tsCount;

  // Stage 0 is the input register; stages 1..IDX_W each resolve one index bit
  logic              stVld [0:IDX_W];
  logic [ADDR_W-1:0] stPc  [0:IDX_W];
  logic [TS_W-1:0]   stTs  [0:IDX_W];
  logic [IDX_W-1:0]  stIdx [0:IDX_W];
  logic              stGe0 [0:IDX_W];

  logic [IDX_W:1]    takeVec;
  logic              ge0First;

  always_ff @(posedge clk) begin
    if (tblWrEn) startTbl[tblWrAddr] <= tblWrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entryCnt <= '0;
      tsCount  <= '0;
    end else begin
      if (cntWrEn) entryCnt <= cntWrData;
      tsCount <= tsCount + TS_W'(1);
    end
  end

  assign ge0First = (entryCnt != '0) && (startTbl[0] <= stPc[0]);

  // One compare per stage: try setting this stage's bit of the index
  for (genvar k = 1; k <= IDX_W; k++) begin : g_stage
    localparam int BITPOS = IDX_W - k;
    logic [IDX_W-1:0] cand;
    assign cand = stIdx[k-1] | (IDX_W'(1) << BITPOS);
    assign takeVec[k] = ({1'b0, cand} < entryCnt) && (startTbl[cand] <= stPc[k-1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= IDX_W; k++) stVld[k] <= 1'b0;
    end else begin
      stVld[0] <= sampleVld;
      for (int k = 1; k <= IDX_W; k++) stVld[k] <= stVld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    stPc[0]  <= sampleAddr;
    stTs[0]  <= tsCount;
    stIdx[0] <= '0;
    stGe0[0] <= 1'b0;
    for (int k = 1; k <= IDX_W; k++) begin
      stPc[k]  <= stPc[k-1];
      stTs[k]  <= stTs[k-1];
      stIdx[k] <= takeVec[k] ? (stIdx[k-1] | (IDX_W'(1) << (IDX_W - k))) : stIdx[k-1];
      stGe0[k] <= (k == 1) ? ge0First : stGe0[k-1];
    end
  end

  assign resVld = stVld[IDX_W];
  assign resIdx = stGe0[IDX_W] ? {1'b0, stIdx[IDX_W]} : UNKNOWN_IDX;
  assign resTs  = stTs[IDX_W];

  // R2: a resolved index lies below the count and its start is not above the PC
  p_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stVld[IDX_W] && stGe0[IDX_W]) |->
      (({1'b0, stIdx[IDX_W]} < entryCnt) && (startTbl[stIdx[IDX_W]] <= stPc[IDX_W])));

  // R3: the unknown index appears only when no entry can match
  p_unknown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stVld[IDX_W] && !stGe0[IDX_W]) |->
      ((entryCnt == '0) || (startTbl[0] > stPc[IDX_W])));

  // R7: the timestamp counter advances by one each clock
  p_ts_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tsCount == TS_W'($past(tsCount) + TS_W'(1))));
endmodule

// File: rtl/pcft_fifo.sv
module pcft_fifo
  import pcft_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifoCmd_t         cmd,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (cmd.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (cmd.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      case ({cmd.push, cmd.pop})
        2'b10:   fillCnt <= fillCnt + CNT_W'(1);
        2'b01:   fillCnt <= fillCnt - CNT_W'(1);
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign full   = (fillCnt == CNT_W'(DEPTH));
  assign empty  = (fillCnt == '0);

  // R10: occupancy never exceeds the depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fillCnt <= CNT_W'(DEPTH));

  // R9: control never pops an empty queue
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.pop |-> !empty);

  // R9: a lone push grows occupancy by exactly one
  p_fill_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.push && !cmd.pop) |=> (fillCnt == CNT_W'($past(fillCnt) + CNT_W'(1))));
endmodule

// File: rtl/pcft_ctrl.sv
module pcft_ctrl
  import pcft_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resVld,
  input  logic [IDX_W:0]    resIdx,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              popReq,
  output fifoCmd_t          cmd,
  output logic [DROP_W-1:0] dropCnt
);
  logic           hasLast;
  logic [IDX_W:0] lastIdx;
  logic           passRec;

  // Change filter: only a new function index survives
  assign passRec  = resVld && (!hasLast || (resIdx != lastIdx));
  assign cmd.push = passRec && !fifoFull;
  assign cmd.pop  = popReq && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hasLast <= 1'b0;
      lastIdx <= '0;
      dropCnt <= '0;
    end else begin
      if (passRec) begin
        hasLast <= 1'b1;
        lastIdx <= resIdx;
      end
      if (passRec && fifoFull && (dropCnt != '1)) dropCnt <= dropCnt + DROP_W'(1);
    end
  end

  // R10: a saturated drop counter stays put
  p_drop_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dropCnt == '1) |=> (dropCnt == '1));

  // R10: a discarded record adds exactly one below saturation
  p_drop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resVld && fifoFull && !cmd.push && (resIdx != lastIdx) && (dropCnt != '1)) |=>
      (dropCnt == DROP_W'($past(dropCnt) + DROP_W'(1))));

  // R5: two back-to-back pushes always carry different indices
  p_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.push && $past(cmd.push) && $past(rst_n)) |-> (resIdx != $past(resIdx)));
endmodule

// File: rtl/pc_func_tracer.sv
module pc_func_tracer
  import pcft_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 8,
  parameter int TS_W       = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrAddr,
  input  logic [ADDR_W-1:0] tblWrData,
  input  logic              cntWrEn,
  input  logic [IDX_W:0]    cntWrData,
  input  logic              lookupEn,
  input  logic              pcValid,
  input  logic [ADDR_W-1:0] pcValue,
  input  logic              outRead,
  output logic              outValid,
  output logic [IDX_W:0]    outIdx,
  output logic [TS_W-1:0]   outTime,
  output logic [DROP_W-1:0] dropCount
);
  localparam int REC_W = IDX_W + 1 + TS_W;

  logic             resVld;
  logic [IDX_W:0]   resIdx;
  logic [TS_W-1:0]  resTs;
  fifoCmd_t         fifoCmd;
  logic             fifoFull, fifoEmpty;
  logic [REC_W-1:0] headRec;

  pcft_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TS_W(TS_W)) lookup_i (
    .clk(clk), .rst_n(rst_n),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .sampleVld(pcValid && lookupEn), .sampleAddr(pcValue),
    .resVld(resVld), .resIdx(resIdx), .resTs(resTs)
  );

  pcft_ctrl #(.IDX_W(IDX_W), .DROP_W(DROP_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .resVld(resVld), .resIdx(resIdx),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .popReq(outRead),
    .cmd(fifoCmd), .dropCnt(dropCount)
  );

  pcft_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .cmd(fifoCmd),
    .wrData({resIdx, resTs}), .rdData(headRec),
    .full(fifoFull), .empty(fifoEmpty)
  );

  assign outValid = !fifoEmpty;
  assign outIdx   = headRec[REC_W-1:TS_W];
  assign outTime  = headRec[TS_W-1:0];
endmodule

// File: tb/pc_func_tracer_tb_top.sv
module pc_func_tracer_tb_top;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int TS_W   = 16;
  localparam int DEPTH  = 4;
  localparam int DROP_W = 3;
  localparam int LAT    = IDX_W + 1;
  localparam int UNK    = 1 << IDX_W;
  localparam int DMAX   = (1 << DROP_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tblWrEn = 1'b0, cntWrEn = 1'b0, lookupEn = 1'b0, pcValid = 1'b0, outRead = 1'b0;
  logic [IDX_W-1:0]  tblWrAddr = '0;
  logic [ADDR_W-1:0] tblWrData = '0, pcValue = '0;
  logic [IDX_W:0]    cntWrData = '0;
  logic              outValid;
  logic [IDX_W:0]    outIdx;
  logic [TS_W-1:0]   outTime;
  logic [DROP_W-1:0] dropCount;

  always #5 clk = ~clk;

  pc_func_tracer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TS_W(TS_W),
                   .FIFO_DEPTH(DEPTH), .DROP_W(DROP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .lookupEn(lookupEn), .pcValid(pcValid), .pcValue(pcValue), .outRead(outRead),
    .outValid(outValid), .outIdx(outIdx), .outTime(outTime), .dropCount(dropCount)
  );

  typedef struct { bit v; int idx; int ts; } ent_t;
  ent_t pipeQ[$];
  ent_t fifoQ[$];
  int   mtab [UNK];
  int   mcnt, tsM, dropM, lastM;
  bit   hasLastM;
  int   checks = 0, failures = 0;
  bit   finished = 0;
  string phaseTag = "R1";

  function automatic int refLookup(int pc);
    int r = UNK;
    for (int i = 0; i < mcnt; i++) if (mtab[i] <= pc) r = i;
    return r;
  endfunction

  // Behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      pipeQ.delete(); fifoQ.delete();
      mcnt = 0; tsM = 0; dropM = 0; lastM = 0; hasLastM = 0;
    end else begin
      bit   full;
      ent_t ex, nw;
      full = (fifoQ.size() == DEPTH);
      ex.v = 0; ex.idx = 0; ex.ts = 0;
      if (pipeQ.size() == LAT) begin ex = pipeQ[0]; pipeQ.delete(0); end
      if (outRead && fifoQ.size() > 0) fifoQ.delete(0);
      if (ex.v && (!hasLastM || ex.idx != lastM)) begin
        hasLastM = 1; lastM = ex.idx;
        if (full) begin if (dropM < DMAX) dropM++; end
        else fifoQ.push_back(ex);
      end
      nw.v = pcValid && lookupEn; nw.idx = refLookup(int'(pcValue)); nw.ts = tsM;
      pipeQ.push_back(nw);
      tsM = (tsM + 1) % (1 << TS_W);
      if (tblWrEn) mtab[tblWrAddr] = int'(tblWrData);
      if (cntWrEn) mcnt = int'(cntWrData);
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", phaseTag, what, act, exp);
    end
  endtask

  // Compare with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(outValid == (fifoQ.size() > 0), "outValid", int'(outValid), int'(fifoQ.size() > 0));
      if (outValid && fifoQ.size() > 0) begin
        check(int'(outIdx) == fifoQ[0].idx, "outIdx", int'(outIdx), fifoQ[0].idx);
        check(int'(outTime) == fifoQ[0].ts, "outTime", int'(outTime), fifoQ[0].ts);
      end
      check(int'(dropCount) == dropM, "dropCount", int'(dropCount), dropM);
    end
  end

  task automatic sample(input int pc);
    @(negedge clk); pcValid = 1'b1; pcValue = ADDR_W'(pc);
  endtask

  task automatic idle(input int n);
    @(negedge clk); pcValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phaseTag = "R1";
    @(negedge clk);
    check(outValid == 1'b0, "reset outValid", int'(outValid), 0);
    check(dropCount == '0, "reset dropCount", int'(dropCount), 0);

    // R11: load ten ascending starts, junk above the count (R4)
    phaseTag = "R11";
    for (int i = 0; i < UNK; i++) begin
      @(negedge clk); tblWrEn = 1'b1; tblWrAddr = IDX_W'(i);
      tblWrData = (i < 10) ? ADDR_W'(16'h1000 + i * 16'h0200) : 16'h0100;
    end
    @(negedge clk); tblWrEn = 1'b0; cntWrEn = 1'b1; cntWrData = 5'd10;
    @(negedge clk); cntWrEn = 1'b0;

    phaseTag = "R8";
    outRead = 1'b1;
    for (int i = 0; i < 6; i++) sample(16'h1000 + i * 16'h0300);
    idle(LAT + 2);

    phaseTag = "R2/R6/R7";
    @(negedge clk); lookupEn = 1'b1;
    for (int i = 0; i < 12; i++) sample(16'h1000 + ((i * 7) % 10) * 16'h0200 + i * 3);
    sample(16'h11FF); sample(16'h1200); sample(16'h2200);
    idle(LAT + 2);

    phaseTag = "R3/R4";
    sample(16'h0000); sample(16'h0FFF); sample(16'hFFFF); sample(16'h0050); sample(16'h2400);
    idle(LAT + 2);

    phaseTag = "R5";
    sample(16'h1400); sample(16'h1410); sample(16'h15FF); sample(16'h1400);
    sample(16'h0010); sample(16'h0020); sample(16'h1600); idle(2); sample(16'h1610);
    idle(LAT + 2);

    phaseTag = "R10";
    outRead = 1'b0;
    for (int i = 0; i < 16; i++) sample((i % 2 == 0) ? 16'h1300 : 16'h1900);
    idle(LAT + 2);

    phaseTag = "R9";
    @(negedge clk); outRead = 1'b1;
    repeat (8) @(negedge clk);
    outRead = 1'b0;
    sample(16'h1A00); sample(16'h1C00); idle(LAT + 1);
    @(negedge clk); outRead = 1'b1;
    @(negedge clk); outRead = 1'b0;
    idle(3);
    @(negedge clk); outRead = 1'b1;
    idle(4);

    phaseTag = "R3";
    @(negedge clk); cntWrEn = 1'b1; cntWrData = '0;
    @(negedge clk); cntWrEn = 1'b0;
    sample(16'h1800); sample(16'h2000); sample(16'h0001);
    idle(LAT + 4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog %s actual=hung expected=done", phaseTag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule